// File: doc/BRIEF.md
# Single-channel DMA transfer engine

This block is one DMA channel that copies elements between a peripheral-side address and a memory-side address over a shared request/grant bus. Software programs it through a small write port with four selectable registers: a configuration word, a 16-bit element count, a peripheral-side address and a memory-side address. It reads back the live count, both live addresses, the configuration and a 4-bit flag group. Every element moved takes one read beat followed by one write beat. Each side has its own element size (1, 2 or 4 bytes) and its own address-increment switch. The element is zero-extended from the source size and truncated to the destination size.

In peripheral mode the channel moves one element for each request the peripheral raises, and it acknowledges each element. In memory-to-memory mode it runs elements back to back with no request. Circular mode reloads the count and both addresses when the count runs out, so the transfer repeats without software help. Sticky flags report half-way, completion and bus error. Each flag can be cleared by writing 1 to it, and the three enables mask them onto one interrupt line. The 2-bit priority field only travels out to an external arbiter.

Top module: `dma_chan`

## Requirements
- R1: After reset, the configuration, count, addresses and flags read 0, `bus_req` is low and `irq_o` is low. While the channel enable (config bit 0) is 0, no bus beat is requested.
- R2: Config bit 4 selects the direction. With 0, the read beat uses the peripheral-side address and the write beat uses the memory-side address. With 1, the two are swapped. The write beat always follows the read beat of the same element and carries the value that was read.
- R3: Bits 9:8 give the peripheral-side element size and bits 11:10 give the memory-side size: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = 4 bytes. When bit 6 is set, the peripheral-side address advances by its element size after each element, and bit 7 does the same for the memory side. A side without its increment bit keeps its address.
- R4: The count drops by exactly one for each element moved. While the channel is enabled, writes to the count and to the addresses are ignored, and a configuration write changes only bits 3:0.
- R5: When the count reaches 0 outside circular operation, the complete flag sets and enable bit 0 clears.
- R6: The half flag sets when the remaining count first equals the programmed count divided by two, rounded down.
- R7: With circular mode (bit 5) set in peripheral mode, reaching 0 reloads the count and both addresses to their programmed values, sets the complete flag and leaves the channel enabled.
- R8: With bit 14 set, elements run back to back with `periph_req` low, and circular mode is ignored: the channel stops at 0.
- R9: In peripheral mode, no element starts while `periph_req` is low. `periph_ack` pulses once per element moved.
- R10: Flag bit order is 0 = any, 1 = complete, 2 = half, 3 = error. Bit 0 reads as the OR of bits 3:1. Writing 1 to a clear bit clears that flag, and clear bit 0 clears all of them.
- R11: `bus_err` on a granted beat sets the error flag, clears the enable bit at once and leaves the count unchanged.
- R12: `irq_o` is (complete AND bit 1) OR (half AND bit 2) OR (error AND bit 3).
- R13: Bits 13:12 are stored and appear on `prio_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 count, 2 peripheral address, 3 memory address |
| reg_wdata | input | 32 | Register write data |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 4 | Write-one-to-clear mask, same order as the flags |
| periph_req | input | 1 | Peripheral asks for one element |
| periph_ack | output | 1 | One element moved for the peripheral |
| bus_req | output | 1 | Beat request |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | 32 | Beat byte address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | 32 | Write data |
| bus_gnt | input | 1 | Beat accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with grant |
| bus_err | input | 1 | Error on the granted beat |
| cfg_o | output | 15 | Configuration readback |
| cnt_o | output | 16 | Live remaining count |
| paddr_o | output | 32 | Live peripheral-side address |
| maddr_o | output | 32 | Live memory-side address |
| status_o | output | 4 | Flags |
| prio_o | output | 2 | Priority level |
| irq_o | output | 1 | Interrupt |

## Verification
The bench sweeps every direction, every pair of element sizes and every increment combination, with and without grant stalls. It compares the whole memory image against a byte-level model. A design that mixed up the size codes or the increment step would leave misplaced or truncated bytes and wrong final addresses. It drives peripheral requests one at a time and checks that the half flag is still clear one element before the half-way point and set on it, so an off-by-one threshold shows. Circular reload is checked for restored addresses and a kept enable. Further runs check that memory-to-memory mode overrides circular, that writes during a transfer do not change the locked registers, that an error aborts with the count intact, and that the interrupt follows the clear-one and clear-all masks.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int CFG_W = 15;

  // configuration bit positions (decoded by software and the bench)
  localparam int B_EN   = 0;
  localparam int B_TCIE = 1;
  localparam int B_HTIE = 2;
  localparam int B_TEIE = 3;
  localparam int B_DIR  = 4;
  localparam int B_CIRC = 5;
  localparam int B_PINC = 6;
  localparam int B_MINC = 7;
  localparam int B_PSZ  = 8;
  localparam int B_MSZ  = 10;
  localparam int B_PRIO = 12;
  localparam int B_M2M  = 14;

  localparam logic [1:0] SEL_CFG   = 2'd0;
  localparam logic [1:0] SEL_CNT   = 2'd1;
  localparam logic [1:0] SEL_PADDR = 2'd2;
  localparam logic [1:0] SEL_MADDR = 2'd3;

  // flag positions
  localparam int F_ANY = 0;
  localparam int F_TC  = 1;
  localparam int F_HT  = 2;
  localparam int F_TE  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;

  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'b00:   elem_bytes = 3'd1;
      2'b01:   elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] elem_mask(input logic [1:0] code);
    case (code)
      2'b00:   elem_mask = 32'h0000_00ff;
      2'b01:   elem_mask = 32'h0000_ffff;
      default: elem_mask = 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              elem_done,
  input  logic              err_hit,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [ADDR_W-1:0] cur_paddr,
  output logic [ADDR_W-1:0] cur_maddr,
  output logic              cnt_nz,
  output logic              ht_evt,
  output logic              tc_evt
);

  logic [CFG_W-1:0]  cfg_d;
  logic [CNT_W-1:0]  prog_cnt_q, prog_cnt_d, cnt_d, cnt_dec;
  logic [ADDR_W-1:0] prog_pa_q, prog_pa_d, prog_ma_q, prog_ma_d;
  logic [ADDR_W-1:0] pa_d, ma_d, pa_step, ma_step;
  logic              last, reload, wr_open;

  assign cnt_dec = cur_cnt - CNT_W'(1);
  assign last    = (cur_cnt == CNT_W'(1));
  assign reload  = cfg_q[B_CIRC] && !cfg_q[B_M2M];
  assign wr_open = !cfg_q[B_EN];
  assign pa_step = cfg_q[B_PINC] ? ADDR_W'(elem_bytes(cfg_q[B_PSZ+:2])) : '0;
  assign ma_step = cfg_q[B_MINC] ? ADDR_W'(elem_bytes(cfg_q[B_MSZ+:2])) : '0;
  assign cnt_nz  = (cur_cnt != '0);
  assign ht_evt  = elem_done && (cnt_dec == (prog_cnt_q >> 1));
  assign tc_evt  = elem_done && last;

  always_comb begin
    cfg_d      = cfg_q;
    prog_cnt_d = prog_cnt_q;
    prog_pa_d  = prog_pa_q;
    prog_ma_d  = prog_ma_q;
    cnt_d      = cur_cnt;
    pa_d       = cur_paddr;
    ma_d       = cur_maddr;
    if (reg_we) begin
      case (reg_sel)
        SEL_CFG: begin
          if (wr_open) cfg_d = reg_wdata[CFG_W-1:0];
          else         cfg_d[B_TEIE:B_EN] = reg_wdata[B_TEIE:B_EN];
        end
        SEL_CNT: if (wr_open) begin
          prog_cnt_d = reg_wdata[CNT_W-1:0];
          cnt_d      = reg_wdata[CNT_W-1:0];
        end
        SEL_PADDR: if (wr_open) begin
          prog_pa_d = reg_wdata[ADDR_W-1:0];
          pa_d      = reg_wdata[ADDR_W-1:0];
        end
        default: if (wr_open) begin
          prog_ma_d = reg_wdata[ADDR_W-1:0];
          ma_d      = reg_wdata[ADDR_W-1:0];
        end
      endcase
    end
    if (elem_done) begin
      if (last && reload) begin
        cnt_d = prog_cnt_q;
        pa_d  = prog_pa_q;
        ma_d  = prog_ma_q;
      end else begin
        cnt_d = cnt_dec;
        pa_d  = cur_paddr + pa_step;
        ma_d  = cur_maddr + ma_step;
        if (last) cfg_d[B_EN] = 1'b0;
      end
    end
    if (err_hit) cfg_d[B_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      prog_cnt_q <= '0;
      prog_pa_q  <= '0;
      prog_ma_q  <= '0;
      cur_cnt    <= '0;
      cur_paddr  <= '0;
      cur_maddr  <= '0;
    end else begin
      cfg_q      <= cfg_d;
      prog_cnt_q <= prog_cnt_d;
      prog_pa_q  <= prog_pa_d;
      prog_ma_q  <= prog_ma_d;
      cur_cnt    <= cnt_d;
      cur_paddr  <= pa_d;
      cur_maddr  <= ma_d;
    end
  end

  // R4: while running, only an element completion moves the count
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[B_EN] && !elem_done |=> $stable(cur_cnt));

  // R5: last element outside circular operation turns the channel off
  p_stop_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done && last && !reload |=> !cfg_q[B_EN]);

  // R7: circular reload keeps the channel running with the programmed count
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done && last && reload && !err_hit && !(reg_we && reg_sel == SEL_CFG)
    |=> cfg_q[B_EN] && (cur_cnt == prog_cnt_q));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              m2m,
  input  logic              dir,
  input  logic [1:0]        psize,
  input  logic [1:0]        msize,
  input  logic              cnt_nz,
  input  logic              periph_req,
  input  logic [ADDR_W-1:0] cur_paddr,
  input  logic [ADDR_W-1:0] cur_maddr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              elem_done,
  output logic              err_hit,
  output logic              periph_ack
);

  seq_st_e           st_q, st_d;
  logic [DATA_W-1:0] data_q;
  logic              cap_en, go;
  logic [1:0]        src_sz, dst_sz;
  logic [ADDR_W-1:0] src_a, dst_a;

  assign src_sz = dir ? msize : psize;
  assign dst_sz = dir ? psize : msize;
  assign src_a  = dir ? cur_maddr : cur_paddr;
  assign dst_a  = dir ? cur_paddr : cur_maddr;
  assign go     = chan_en && cnt_nz && (m2m || periph_req);

  always_comb begin
    st_d      = st_q;
    cap_en    = 1'b0;
    elem_done = 1'b0;
    err_hit   = 1'b0;
    case (st_q)
      ST_IDLE: if (go) st_d = ST_RD;
      ST_RD: begin
        if (!chan_en) st_d = ST_IDLE;
        else if (bus_gnt) begin
          if (bus_err) begin
            err_hit = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            cap_en = 1'b1;
            st_d   = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (!chan_en) st_d = ST_IDLE;
        else if (bus_gnt) begin
          st_d = ST_IDLE;
          if (bus_err) err_hit   = 1'b1;
          else         elem_done = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= bus_rdata & DATA_W'(elem_mask(src_sz));
  end

  assign bus_req    = (st_q != ST_IDLE);
  assign bus_we     = (st_q == ST_WR);
  assign bus_addr   = (st_q == ST_WR) ? dst_a : src_a;
  assign bus_size   = (st_q == ST_WR) ? dst_sz : src_sz;
  assign bus_wdata  = data_q;
  assign periph_ack = elem_done && !m2m;

  // R1: a disabled channel stops requesting the bus
  p_off_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !bus_req);

  // R2: an accepted read beat is followed by the write beat
  p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_gnt && !bus_err && chan_en |=> bus_req && bus_we);

  // R9: in peripheral mode an idle channel waits for a request
  p_wait_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && !m2m && !periph_req |=> !bus_req);

  // R11: a bus error ends the element at once
  p_err_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> !bus_req);

endmodule

// File: rtl/dma_flags.sv
module dma_flags
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tc_evt,
  input  logic       ht_evt,
  input  logic       err_evt,
  input  logic       clr_we,
  input  logic [3:0] clr_bits,
  input  logic [2:0] irq_en,
  output logic [3:0] status,
  output logic       irq
);

  logic [2:0] flg_q, flg_d, set_v, clr_v;

  assign set_v = {err_evt, ht_evt, tc_evt};
  assign clr_v = !clr_we ? 3'b000 : (clr_bits[F_ANY] ? 3'b111 : clr_bits[F_TE:F_TC]);

  always_comb begin
    flg_d = (flg_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign status = {flg_q, |flg_q};
  assign irq    = |(flg_q & irq_en);

  // R10: clearing through the any bit empties the whole group
  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && clr_bits[F_ANY] && !(|set_v) |=> status == 4'b0000);

  // R11: a bus error always leaves the error flag set
  p_err_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> status[F_TE]);

  // R12: the interrupt never fires without a raised flag
  p_irq_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[F_ANY]);

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              clr_we,
  input  logic [3:0]        clr_bits,
  input  logic              periph_req,
  output logic              periph_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [3:0]        status_o,
  output logic [1:0]        prio_o,
  output logic              irq_o
);

  logic rst_n, elem_done, err_hit, cnt_nz, ht_evt, tc_evt;
  logic [CFG_W-1:0] cfg;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .elem_done(elem_done), .err_hit(err_hit),
    .cfg_q(cfg), .cur_cnt(cnt_o), .cur_paddr(paddr_o), .cur_maddr(maddr_o),
    .cnt_nz(cnt_nz), .ht_evt(ht_evt), .tc_evt(tc_evt)
  );

  dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .chan_en(cfg[B_EN]), .m2m(cfg[B_M2M]), .dir(cfg[B_DIR]),
    .psize(cfg[B_PSZ+:2]), .msize(cfg[B_MSZ+:2]),
    .cnt_nz(cnt_nz), .periph_req(periph_req),
    .cur_paddr(paddr_o), .cur_maddr(maddr_o),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .elem_done(elem_done), .err_hit(err_hit), .periph_ack(periph_ack)
  );

  dma_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .tc_evt(tc_evt), .ht_evt(ht_evt), .err_evt(err_hit),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .irq_en({cfg[B_TEIE], cfg[B_HTIE], cfg[B_TCIE]}),
    .status(status_o), .irq(irq_o)
  );

  assign cfg_o  = cfg;
  assign prio_o = cfg[B_PRIO+:2];

endmodule

// File: tb/sim_dma_chan.sv
`timescale 1ns/1ps
module sim_dma_chan;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        reg_we, clr_we, periph_req, periph_ack;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [3:0]  clr_bits;
  logic        bus_req, bus_we, bus_gnt, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic [14:0] cfg_o;
  logic [15:0] cnt_o;
  logic [31:0] paddr_o, maddr_o;
  logic [3:0]  status_o;
  logic [1:0]  prio_o;
  logic        irq_o;

  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  logic        stall_en, err_arm;
  int          cyc;
  int          total, bad;

  always #2.5 clk = ~clk;

  dma_chan u0 (
    .clk(clk), .rst_ni(rst_ni), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .clr_we(clr_we), .clr_bits(clr_bits),
    .periph_req(periph_req), .periph_ack(periph_ack),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .cfg_o(cfg_o), .cnt_o(cnt_o),
    .paddr_o(paddr_o), .maddr_o(maddr_o), .status_o(status_o),
    .prio_o(prio_o), .irq_o(irq_o)
  );

  // byte-addressed memory model with optional grant stalls
  assign bus_gnt = bus_req && !(stall_en && cyc[0]);
  assign bus_err = bus_req && err_arm;

  always_comb begin
    for (int b = 0; b < 4; b++) bus_rdata[b*8 +: 8] = mem[8'(bus_addr[7:0] + 8'(b))];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && bus_we && bus_gnt && !bus_err) begin
      for (int b = 0; b < 4; b++)
        if (b < nbytes(bus_size)) mem[8'(bus_addr[7:0] + 8'(b))] <= bus_wdata[b*8 +: 8];
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL R1 watchdog expired act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int nbytes(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mkcfg(
    input logic en, input logic tcie, input logic htie, input logic teie,
    input logic dir, input logic circ, input logic pinc, input logic minc,
    input logic [1:0] psz, input logic [1:0] msz, input logic [1:0] prio,
    input logic m2m);
    return {17'd0, m2m, prio, msz, psz, minc, pinc, circ, dir, teie, htie, tcie, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wclr(input logic [3:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_bits = m;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic wait_off();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!cfg_o[0]) break;
    end
    @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] n, input logic [31:0] pa, input logic [31:0] ma);
    wreg(2'd1, {16'd0, n});
    wreg(2'd2, pa);
    wreg(2'd3, ma);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0;
    reg_we = 0; reg_sel = 0; reg_wdata = 0; clr_we = 0; clr_bits = 0;
    periph_req = 0; stall_en = 0; err_arm = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 cfg", {17'd0, cfg_o}, 32'd0);
    chk("R1 cnt", {16'd0, cnt_o}, 32'd0);
    chk("R1 status", {28'd0, status_o}, 32'd0);
    chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);

    // R2 R3 R8: sweep direction, sizes and increments in memory-to-memory mode
    for (int dir = 0; dir < 2; dir++)
      for (int ps = 0; ps < 3; ps++)
        for (int ms = 0; ms < 3; ms++)
          for (int inc = 0; inc < 4; inc++) begin
            int sb, db, ss, ds, mism;
            logic sinc, dinc;
            logic [31:0] v;
            for (int i = 0; i < 256; i++) begin
              mem[i] = 8'(i * 7 + 3);
              shadow[i] = 8'(i * 7 + 3);
            end
            sb   = dir ? 'h80 : 'h10;
            db   = dir ? 'h10 : 'h80;
            ss   = dir ? nbytes(2'(ms)) : nbytes(2'(ps));
            ds   = dir ? nbytes(2'(ps)) : nbytes(2'(ms));
            sinc = dir ? inc[1] : inc[0];
            dinc = dir ? inc[0] : inc[1];
            for (int k = 0; k < 4; k++) begin
              int sa, da;
              sa = sb + (sinc ? k * ss : 0);
              da = db + (dinc ? k * ds : 0);
              v = 0;
              for (int b = 0; b < ss; b++) v[b*8 +: 8] = shadow[(sa + b) & 255];
              for (int b = 0; b < ds; b++) shadow[(da + b) & 255] = v[b*8 +: 8];
            end
            stall_en = inc[0] ^ dir[0];
            wclr(4'b0001);
            setup(16'd4, 32'h10, 32'h80);
            wreg(2'd0, mkcfg(1, 0, 0, 0, dir[0], 0, inc[0], inc[1], 2'(ps), 2'(ms), 2'd0, 1));
            wait_off();
            mism = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) mism++;
            chk("R2 R3 memory image", 32'(mism), 32'd0);
            chk("R3 paddr final", paddr_o, 32'h10 + (inc[0] ? 4 * nbytes(2'(ps)) : 0));
            chk("R3 maddr final", maddr_o, 32'h80 + (inc[1] ? 4 * nbytes(2'(ms)) : 0));
            chk("R4 cnt zero", {16'd0, cnt_o}, 32'd0);
            chk("R5 R6 flags", {28'd0, status_o}, 32'b0111);
            chk("R5 enable off", {31'd0, cfg_o[0]}, 32'd0);
          end
    stall_en = 0;

    // R9 R6: peripheral mode, one element per request
    wclr(4'b0001);
    setup(16'd5, 32'h40, 32'hA0);
    wreg(2'd0, mkcfg(1, 0, 0, 0, 0, 0, 0, 1, 2'd2, 2'd2, 2'd0, 0));
    repeat (20) @(negedge clk);
    chk("R9 no request no move", {16'd0, cnt_o}, 32'd5);
    for (int e = 0; e < 5; e++) begin
      int acks;
      periph_req = 1'b1;
      acks = 0;
      for (int t = 0; t < 100; t++) begin
        @(negedge clk);
        if (periph_ack) begin acks++; break; end
      end
      periph_req = 1'b0;
      @(negedge clk);
      chk("R9 one ack", 32'(acks), 32'd1);
      chk("R4 step count", {16'd0, cnt_o}, 32'(4 - e));
      chk("R6 half flag", {31'd0, status_o[2]}, ((4 - e) <= 2) ? 32'd1 : 32'd0);
    end
    chk("R5 stopped", {31'd0, cfg_o[0]}, 32'd0);

    // R7: circular reload
    wclr(4'b0001);
    setup(16'd3, 32'h20, 32'h90);
    wreg(2'd0, mkcfg(1, 0, 0, 0, 0, 1, 1, 1, 2'd0, 2'd0, 2'd0, 0));
    periph_req = 1'b1;
    begin
      int acks;
      acks = 0;
      for (int t = 0; t < 200 && acks < 3; t++) begin
        @(negedge clk);
        if (periph_ack) begin
          acks++;
          if (acks == 3) periph_req = 1'b0;
        end
      end
    end
    periph_req = 1'b0;
    @(negedge clk);
    chk("R7 count reload", {16'd0, cnt_o}, 32'd3);
    chk("R7 paddr reload", paddr_o, 32'h20);
    chk("R7 maddr reload", maddr_o, 32'h90);
    chk("R7 still enabled", {31'd0, cfg_o[0]}, 32'd1);
    chk("R7 complete flag", {31'd0, status_o[1]}, 32'd1);
    wreg(2'd0, 32'd0);
    chk("R4 disable while running", {31'd0, cfg_o[0]}, 32'd0);

    // R8: memory-to-memory ignores circular
    wclr(4'b0001);
    setup(16'd2, 32'h10, 32'h80);
    wreg(2'd0, mkcfg(1, 0, 0, 0, 0, 1, 1, 1, 2'd0, 2'd0, 2'd0, 1));
    wait_off();
    chk("R8 stops at zero", {16'd0, cnt_o}, 32'd0);
    chk("R8 enable off", {31'd0, cfg_o[0]}, 32'd0);

    // R4: locked registers while enabled
    wclr(4'b0001);
    setup(16'd7, 32'h30, 32'h90);
    wreg(2'd0, mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 0));
    wreg(2'd1, 32'd9);
    wreg(2'd2, 32'h44);
    wreg(2'd0, mkcfg(1, 1, 0, 0, 0, 0, 0, 0, 2'd2, 2'd0, 2'd0, 0));
    chk("R4 count locked", {16'd0, cnt_o}, 32'd7);
    chk("R4 paddr locked", paddr_o, 32'h30);
    chk("R4 size locked", {30'd0, cfg_o[9:8]}, 32'd0);
    chk("R4 enables writable", {31'd0, cfg_o[1]}, 32'd1);
    wreg(2'd0, 32'd0);

    // R10 R12: flags, clears and interrupt masking
    wclr(4'b0001);
    setup(16'd2, 32'h10, 32'h80);
    wreg(2'd0, mkcfg(1, 1, 0, 0, 0, 0, 1, 1, 2'd0, 2'd0, 2'd0, 1));
    wait_off();
    chk("R10 flags set", {28'd0, status_o}, 32'b0111);
    chk("R12 irq on complete", {31'd0, irq_o}, 32'd1);
    wreg(2'd0, mkcfg(0, 0, 1, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 1));
    chk("R12 irq on half", {31'd0, irq_o}, 32'd1);
    wclr(4'b0100);
    chk("R10 clear half only", {28'd0, status_o}, 32'b0011);
    chk("R12 irq masked", {31'd0, irq_o}, 32'd0);
    wclr(4'b0001);
    chk("R10 clear all", {28'd0, status_o}, 32'd0);

    // R11: bus error
    err_arm = 1'b1;
    setup(16'd4, 32'h10, 32'h80);
    wreg(2'd0, mkcfg(1, 0, 0, 1, 0, 0, 1, 1, 2'd0, 2'd0, 2'd0, 1));
    wait_off();
    err_arm = 1'b0;
    chk("R11 error flags", {28'd0, status_o}, 32'b1001);
    chk("R11 count kept", {16'd0, cnt_o}, 32'd4);
    chk("R11 enable off", {31'd0, cfg_o[0]}, 32'd0);
    chk("R12 irq on error", {31'd0, irq_o}, 32'd1);
    wclr(4'b1000);

    // R13: priority readback
    wreg(2'd0, mkcfg(0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd2, 0));
    chk("R13 priority", {30'd0, prio_o}, 32'd2);
    wreg(2'd0, mkcfg(0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd3, 0));
    chk("R13 priority max", {30'd0, prio_o}, 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule